// File: doc/BRIEF.md
# Slot Window Change Monitor

This block sits behind a lighting-control frame receiver that delivers one slot per cycle. The host picks a contiguous span of slots by programming a first slot and a slot count. For frames with the null start code, the block keeps a private copy of that span. As each slot arrives it is compared with the copy from the previous frame. A change interrupt is raised when the frame ends if any slot inside the span changed. A second interrupt reports every accepted frame whatever the window setting is. Frames that carry the remote-management start code (0xCC) are dropped completely.

Frames with any other start code are alternate-start-code frames. They are kept whole in a second buffer, and their length is recorded. The host reads either buffer through a small command port. A read command opens a burst. Each byte request in that burst returns one byte. A burst returns at most a fixed number of bytes, and a following read command of the same kind carries on from where the last one stopped. The running offset goes back to the first byte in two cases: after the last byte of the buffer has been read, or when any other command arrives.

Top module: `slot_window_monitor`

## Requirements
- R1: After reset both interrupts are low, `rd_valid` is low, and every stored byte of both buffers reads as 0x00.
- R2: Only null-start-code (0x00) slots whose index lies in [`win_start`, `win_start` + span) are stored. The span is `win_len` clipped to `MAX_SLOTS` − `win_start`. Window byte k holds slot `win_start` + k.
- R3: One cycle after `frame_end` of a null-start-code frame, `irq_change` is high if some in-window slot value differed from the stored byte. Slots outside the window, slots absent from a short frame and repeated values leave it unchanged.
- R4: One cycle after `frame_end`, `irq_frame` is high for any start code except 0xCC. A 0xCC frame stores nothing and raises no interrupt. `start_code` is held for the whole frame, including the `frame_end` cycle.
- R5: Both interrupts stay high until cleared: `irq_clr` bit 0 clears `irq_change` and bit 1 clears `irq_frame`. A set in the same cycle wins over a clear.
- R6: `cmd_op` 0 opens a window read and 1 opens an alternate-frame read. For each `rd_req` in an open burst, `rd_valid` and `rd_data` show the next byte one cycle later. A burst gives at most `CHUNK_MAX` bytes. Requests outside a burst, or in the same cycle as a command, return nothing.
- R7: A read command of the same kind as the previous read continues at the offset where the previous burst stopped.
- R8: After the last byte of the buffer (window span or alternate-frame length) is returned, the offset goes back to 0 and the burst closes.
- R9: `cmd_op` 2 or 3, or a read of the other kind, sets the offset back to 0. Codes 2 and 3 also close any open burst.
- R10: An alternate-frame read returns slots 0 to L−1 of the last accepted alternate frame, where L is its highest slot index plus one.
- R11: With a span of zero, a window read returns no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | 1 | A slot is present this cycle |
| slot_idx | input | IW | Slot index counted from 0 |
| slot_data | input | 8 | Slot value |
| start_code | input | 8 | Start code of the current frame |
| frame_end | input | 1 | Frame finished this cycle |
| win_start | input | IW | First slot of the window |
| win_len | input | IW+1 | Requested window length in slots |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 change, bit 1 frame |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 window read, 1 alternate read, 2/3 other |
| rd_req | input | 1 | Byte request within a burst |
| irq_change | output | 1 | Window data changed |
| irq_frame | output | 1 | Frame accepted |
| rd_valid | output | 1 | `rd_data` holds a requested byte |
| rd_data | output | 8 | Returned byte |

## Verification
The bench builds the block with `MAX_SLOTS` = 16 and `CHUNK_MAX` = 4. With these values every window start can be swept against lengths of zero, one, a middle value, the full depth and beyond the end. The sweep therefore covers clipping at the top slot, windows that end in the middle of a chunk and windows that need several chunks. Because the chunk is small, each full read of the window takes several bursts. This puts the offset carry-over, the return to zero at the end of the window and the reset of the offset by other commands at many different positions.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam logic [7:0] SC_NULL = 8'h00;
  localparam logic [7:0] SC_RDM  = 8'hCC;

  localparam logic [1:0] OP_RD_WIN = 2'd0;
  localparam logic [1:0] OP_RD_ALT = 2'd1;

  // Window length after clipping at the top of the slot space.
  function automatic int win_span(input int ws, input int wl, input int max_slots);
    return (wl < max_slots - ws) ? wl : max_slots - ws;
  endfunction

  function automatic bit in_span(input int idx, input int ws, input int span);
    return (idx >= ws) && (idx < ws + span);
  endfunction
endpackage

// File: rtl/swm_capture.sv
module swm_capture #(
  parameter int MAX_SLOTS = 512,
  localparam int IW = $clog2(MAX_SLOTS),
  localparam int LW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_valid,
  input  logic [IW-1:0] slot_idx,
  input  logic [7:0]    slot_data,
  input  logic [7:0]    start_code,
  input  logic          frame_end,
  input  logic [IW-1:0] win_start,
  input  logic [LW-1:0] win_len,
  input  logic          rd_sel,
  input  logic [IW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic [LW-1:0] win_span_q,
  output logic [LW-1:0] alt_len,
  output logic          change_evt,
  output logic          frame_ok
);
  import swm_pkg::*;

  logic [7:0]    win_mem [MAX_SLOTS];
  logic [7:0]    alt_mem [MAX_SLOTS];
  logic          is_null, is_rdm, win_hit, slot_diff, alt_wr, chg_acc;
  logic [IW-1:0] woff;
  logic [LW-1:0] alt_run, run_next, idx_p1;

  assign is_null    = (start_code == SC_NULL);
  assign is_rdm     = (start_code == SC_RDM);
  assign win_span_q = LW'(win_span(int'(win_start), int'(win_len), MAX_SLOTS));
  assign win_hit    = slot_valid && is_null &&
                      in_span(int'(slot_idx), int'(win_start), int'(win_span_q));
  assign woff       = slot_idx - win_start;
  assign slot_diff  = win_hit && (win_mem[woff] != slot_data);
  assign alt_wr     = slot_valid && !is_null && !is_rdm;
  assign idx_p1     = {1'b0, slot_idx} + LW'(1);
  assign run_next   = (alt_wr && idx_p1 > alt_run) ? idx_p1 : alt_run;

  assign change_evt = frame_end && is_null && (chg_acc || slot_diff);
  assign frame_ok   = frame_end && !is_rdm;
  assign rd_byte    = rd_sel ? alt_mem[rd_addr] : win_mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SLOTS; i++) begin
        win_mem[i] <= '0;
        alt_mem[i] <= '0;
      end
      chg_acc <= 1'b0;
      alt_run <= '0;
      alt_len <= '0;
    end else begin
      if (win_hit) win_mem[woff] <= slot_data;
      if (alt_wr)  alt_mem[slot_idx] <= slot_data;
      if (frame_end) begin
        chg_acc <= 1'b0;
        alt_run <= '0;
        if (!is_null && !is_rdm) alt_len <= run_next;
      end else begin
        chg_acc <= chg_acc | slot_diff;
        alt_run <= run_next;
      end
    end
  end
endmodule

// File: rtl/swm_reader.sv
module swm_reader #(
  parameter int MAX_SLOTS = 512,
  parameter int CHUNK_MAX = 128,
  localparam int IW = $clog2(MAX_SLOTS),
  localparam int LW = IW + 1,
  localparam int CW = $clog2(CHUNK_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          rd_req,
  input  logic [7:0]    byte_in,
  input  logic [LW-1:0] win_len_eff,
  input  logic [LW-1:0] alt_len,
  output logic          rd_sel,
  output logic [IW-1:0] rd_addr,
  output logic [LW-1:0] rd_off,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);
  import swm_pkg::*;

  logic          burst_on, has_byte, is_read, new_sel;
  logic [CW-1:0] cnt;
  logic [LW-1:0] end_len, off_p1;

  assign end_len  = rd_sel ? alt_len : win_len_eff;
  assign has_byte = burst_on && (rd_off < end_len);
  assign rd_addr  = rd_off[IW-1:0];
  assign off_p1   = rd_off + LW'(1);
  assign is_read  = (cmd_op == OP_RD_WIN) || (cmd_op == OP_RD_ALT);
  assign new_sel  = (cmd_op == OP_RD_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel   <= 1'b0;
      rd_off   <= '0;
      burst_on <= 1'b0;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid) begin
        if (is_read) begin
          if (new_sel != rd_sel) rd_off <= '0;
          rd_sel   <= new_sel;
          burst_on <= 1'b1;
          cnt      <= '0;
        end else begin
          rd_off   <= '0;
          burst_on <= 1'b0;
        end
      end else if (rd_req && burst_on) begin
        if (has_byte) begin
          rd_valid <= 1'b1;
          rd_data  <= byte_in;
          cnt      <= cnt + CW'(1);
          if (off_p1 == end_len) begin
            rd_off   <= '0;
            burst_on <= 1'b0;
          end else begin
            rd_off <= off_p1;
          end
          if (cnt + CW'(1) == CW'(CHUNK_MAX)) burst_on <= 1'b0;
        end else begin
          rd_off   <= '0;
          burst_on <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/swm_irq.sv
module swm_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       change_evt,
  input  logic       frame_ok,
  input  logic [1:0] irq_clr,
  output logic       irq_change,
  output logic       irq_frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_change <= 1'b0;
      irq_frame  <= 1'b0;
    end else begin
      if (change_evt)      irq_change <= 1'b1;
      else if (irq_clr[0]) irq_change <= 1'b0;
      if (frame_ok)        irq_frame  <= 1'b1;
      else if (irq_clr[1]) irq_frame  <= 1'b0;
    end
  end
endmodule

// File: rtl/slot_window_monitor.sv
module slot_window_monitor #(
  parameter int MAX_SLOTS = 512,
  parameter int CHUNK_MAX = 128,
  localparam int IW = $clog2(MAX_SLOTS),
  localparam int LW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_valid,
  input  logic [IW-1:0] slot_idx,
  input  logic [7:0]    slot_data,
  input  logic [7:0]    start_code,
  input  logic          frame_end,
  input  logic [IW-1:0] win_start,
  input  logic [LW-1:0] win_len,
  input  logic [1:0]    irq_clr,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          rd_req,
  output logic          irq_change,
  output logic          irq_frame,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);
  // Named internal events, also observed by the bound checker.
  logic          change_evt, frame_ok, rd_sel;
  logic [IW-1:0] rd_addr;
  logic [7:0]    rd_byte;
  logic [LW-1:0] win_span_q, alt_len, rd_off;

  swm_capture #(.MAX_SLOTS(MAX_SLOTS)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .slot_valid(slot_valid), .slot_idx(slot_idx), .slot_data(slot_data),
    .start_code(start_code), .frame_end(frame_end),
    .win_start(win_start), .win_len(win_len),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .win_span_q(win_span_q), .alt_len(alt_len),
    .change_evt(change_evt), .frame_ok(frame_ok)
  );

  swm_reader #(.MAX_SLOTS(MAX_SLOTS), .CHUNK_MAX(CHUNK_MAX)) u_reader (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rd_req(rd_req),
    .byte_in(rd_byte), .win_len_eff(win_span_q), .alt_len(alt_len),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_off(rd_off),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  swm_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .change_evt(change_evt), .frame_ok(frame_ok), .irq_clr(irq_clr),
    .irq_change(irq_change), .irq_frame(irq_frame)
  );
endmodule

// File: rtl/swm_checker.sv
module swm_checker #(
  parameter int MAX_SLOTS = 512,
  parameter int CHUNK_MAX = 128,
  localparam int IW = $clog2(MAX_SLOTS),
  localparam int LW = IW + 1,
  localparam int KW = $clog2(CHUNK_MAX + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          change_evt,
  input logic          frame_ok,
  input logic          frame_end,
  input logic [7:0]    start_code,
  input logic [1:0]    irq_clr,
  input logic          irq_change,
  input logic          irq_frame,
  input logic          cmd_valid,
  input logic          rd_req,
  input logic          rd_valid,
  input logic [LW-1:0] rd_off
);
  logic [KW-1:0] burst_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         burst_bytes <= '0;
    else if (cmd_valid) burst_bytes <= '0;
    else if (rd_valid)  burst_bytes <= burst_bytes + KW'(1);
  end

  // R3
  chg_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    change_evt |=> irq_change);

  // R4
  frm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> irq_frame);

  // R4
  frm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_frame) |-> $past(frame_end && start_code != 8'hCC));

  // R5
  chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_change) |-> $past(irq_clr[0]));

  // R5
  frm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_frame) |-> $past(irq_clr[1]));

  // R6
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req && !cmd_valid));

  // R6
  chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_bytes <= KW'(CHUNK_MAX));

  // R8
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_off < LW'(MAX_SLOTS));
endmodule

bind slot_window_monitor swm_checker #(.MAX_SLOTS(MAX_SLOTS), .CHUNK_MAX(CHUNK_MAX)) u_swm_chk (
  .clk(clk), .rst_n(rst_n), .change_evt(change_evt), .frame_ok(frame_ok),
  .frame_end(frame_end), .start_code(start_code), .irq_clr(irq_clr),
  .irq_change(irq_change), .irq_frame(irq_frame), .cmd_valid(cmd_valid),
  .rd_req(rd_req), .rd_valid(rd_valid), .rd_off(rd_off)
);

// File: tb/slot_window_monitor_tb.sv
module slot_window_monitor_tb;
  localparam int MAX   = 16;
  localparam int CHUNK = 4;
  localparam int IW    = 4;
  localparam int LW    = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, slot_valid, frame_end, cmd_valid, rd_req;
  logic [IW-1:0] slot_idx, win_start;
  logic [LW-1:0] win_len;
  logic [7:0]    slot_data, start_code;
  logic [1:0]    irq_clr, cmd_op;
  logic          irq_change, irq_frame, rd_valid;
  logic [7:0]    rd_data;

  slot_window_monitor #(.MAX_SLOTS(MAX), .CHUNK_MAX(CHUNK)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_idx(slot_idx),
    .slot_data(slot_data), .start_code(start_code), .frame_end(frame_end),
    .win_start(win_start), .win_len(win_len), .irq_clr(irq_clr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rd_req(rd_req),
    .irq_change(irq_change), .irq_frame(irq_frame),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_win [MAX];
  logic [7:0] m_alt [MAX];
  int  m_alt_len = 0, m_ws = 0, m_wl = 0, m_off = 0, m_sel = 0, m_cnt = 0;
  bit  m_act = 0, exp_chg = 0, exp_frm = 0;

  function automatic int span();
    return (m_wl < MAX - m_ws) ? m_wl : MAX - m_ws;
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed, input int alt);
    logic [7:0] v;
    v = 8'((i * 37 + seed * 11 + 5) & 255);
    if (i == alt) v = v ^ 8'h5A;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_win(input int ws, input int wl);
    @(negedge clk);
    win_start = IW'(ws); win_len = LW'(wl);
    m_ws = ws; m_wl = wl;
  endtask

  task automatic send_frame(input logic [7:0] sc, input int n, input int seed, input int alt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slot_valid = 1'b1; slot_idx = IW'(i); slot_data = pat(i, seed, alt); start_code = sc;
      if (sc == 8'h00) begin
        if (i >= m_ws && i < m_ws + span()) begin
          if (m_win[i - m_ws] != slot_data) exp_chg = 1;
          m_win[i - m_ws] = slot_data;
        end
      end else if (sc != 8'hCC) begin
        m_alt[i] = slot_data;
      end
    end
    @(negedge clk);
    slot_valid = 1'b0; frame_end = 1'b1; start_code = sc;
    if (sc != 8'hCC) exp_frm = 1;
    if (sc != 8'h00 && sc != 8'hCC) m_alt_len = n;
    @(negedge clk);
    frame_end = 1'b0;
    chk("R3 irq_change after frame", int'(irq_change), int'(exp_chg));
    chk("R4 irq_frame after frame", int'(irq_frame), int'(exp_frm));
  endtask

  task automatic clr(input logic [1:0] bits);
    @(negedge clk); irq_clr = bits;
    @(negedge clk); irq_clr = 2'b00;
    if (bits[0]) exp_chg = 0;
    if (bits[1]) exp_frm = 0;
    chk("R5 irq_change after clear", int'(irq_change), int'(exp_chg));
    chk("R5 irq_frame after clear", int'(irq_frame), int'(exp_frm));
  endtask

  task automatic cmd(input int op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'(op);
    @(negedge clk); cmd_valid = 1'b0;
    if (op < 2) begin
      if (op != m_sel) m_off = 0;
      m_sel = op; m_act = 1; m_cnt = 0;
    end else begin
      m_off = 0; m_act = 0;
    end
  endtask

  task automatic req(input string tag);
    int len, ev, ed;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    len = (m_sel == 1) ? m_alt_len : span();
    ev = 0; ed = 0;
    if (m_act && m_off < len) begin
      ev = 1;
      ed = (m_sel == 1) ? int'(m_alt[m_off]) : int'(m_win[m_off]);
      m_off++; m_cnt++;
      if (m_off == len) begin m_off = 0; m_act = 0; end
      if (m_cnt == CHUNK) m_act = 0;
    end else if (m_act) begin
      m_act = 0; m_off = 0;
    end
    chk({tag, " rd_valid"}, int'(rd_valid), ev);
    if (ev == 1) chk({tag, " rd_data"}, int'(rd_data), ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int wls [5] = '{0, 1, 5, 16, 20};
    for (int i = 0; i < MAX; i++) begin m_win[i] = 8'h00; m_alt[i] = 8'h00; end
    rst_n = 1'b0; slot_valid = 0; frame_end = 0; cmd_valid = 0; rd_req = 0;
    slot_idx = '0; slot_data = '0; start_code = '0; irq_clr = '0; cmd_op = '0;
    win_start = '0; win_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_change reset", int'(irq_change), 0);
    chk("R1 irq_frame reset", int'(irq_frame), 0);
    chk("R1 rd_valid reset", int'(rd_valid), 0);
    set_win(0, 16);
    cmd(0);
    repeat (5) req("R1 window zero");
    cmd(1);
    repeat (2) req("R11 alt empty");

    // R2 R3 R7 R8 R11: sweep every start against several lengths
    for (int ws = 0; ws < MAX; ws++) begin
      for (int k = 0; k < 5; k++) begin
        set_win(ws, wls[k]);
        send_frame(8'h00, MAX, ws * 5 + k, -1);
        clr(2'b11);
        for (int c = 0; c < 5; c++) begin
          cmd(0);
          repeat (CHUNK + 1) req("R2 R7 R8 R11 window read");
        end
      end
    end

    // R3: identical frame, change outside window, short frame
    set_win(4, 4);
    send_frame(8'h00, MAX, 99, -1);
    clr(2'b11);
    send_frame(8'h00, MAX, 99, -1);
    chk("R3 repeat no change", int'(irq_change), 0);
    send_frame(8'h00, MAX, 99, 10);
    chk("R3 outside window no change", int'(irq_change), 0);
    send_frame(8'h00, 3, 99, -1);
    chk("R3 short frame no change", int'(irq_change), 0);
    send_frame(8'h00, MAX, 99, 6);
    chk("R3 in-window change", int'(irq_change), 1);

    // R5: clear only the change flag
    clr(2'b01);
    chk("R5 frame flag kept", int'(irq_frame), 1);
    clr(2'b10);

    // R4: 0xCC frames ignored
    send_frame(8'hCC, MAX, 7, -1);
    chk("R4 rdm no frame irq", int'(irq_frame), 0);
    cmd(0);
    repeat (CHUNK + 1) req("R4 window untouched");

    // R10: alternate frames, long then short
    send_frame(8'h17, 10, 3, -1);
    clr(2'b11);
    for (int c = 0; c < 4; c++) begin
      cmd(1);
      repeat (CHUNK + 1) req("R10 alt read");
    end
    send_frame(8'h91, 6, 8, -1);
    cmd(1);
    repeat (CHUNK + 1) req("R10 short alt read");

    // R9: other command and kind switch reset the offset
    set_win(0, 16);
    send_frame(8'h00, MAX, 42, -1);
    cmd(0); repeat (2) req("R9 before other");
    cmd(2); req("R9 closed burst");
    cmd(0); repeat (2) req("R9 after other");
    cmd(1); repeat (2) req("R9 switch to alt");
    cmd(0); repeat (3) req("R9 switch back");
    cmd(0); repeat (2) req("R7 continue");
    cmd(3); cmd(0); req("R9 op3 reset");

    // R6: cmd and rd_req together returns nothing
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0; rd_req = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; rd_req = 1'b0;
    chk("R6 req with cmd ignored", int'(rd_valid), 0);
    if (0 != m_sel) m_off = 0;
    m_sel = 0; m_act = 1; m_cnt = 0;
    req("R6 first after cmd");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule